// File: doc/BRIEF.md
# Fan Spin-Up Sequencer

This block starts a fan. When the fan enable goes high, the duty sent to the PWM generator is forced to full scale, so the fan can overcome inertia. It then hands over to the requested running duty. By default, hand-over happens once the tachometer shows that the fan is turning, which means two tach edges have been counted. A fan that is slow to start therefore gets only the full-speed burst it needs.

A 3-bit window select sets how long the sequencer waits for those edges. If the window expires first, a sticky failure interrupt is raised and the fan still drops to its running duty. A mode input replaces tach detection with a pure fixed-time burst of the selected length. Time is counted in ticks of an external one-millisecond strobe. The tach input is an already-synchronized single-cycle edge pulse.

Top module: `fan_spinup_ctrl`

## Requirements
- R1: During and after reset, with the enable low, `duty_out` is 0, `spinning_up` is 0 and `irq_fail` is 0.
- R2: One clock edge after `fan_en` is seen high in the idle state, `spinning_up` is 1 and `duty_out` is all ones.
- R3: In tach mode (`fixed_mode`=0), the clock edge that samples the second `tach_pulse` of a spin-up ends spin-up. Straight after that edge, `spinning_up` is 0 and `duty_out` equals `run_duty`.
- R4: `tmo_sel` gives the window length in `ms_tick` pulses: 001=100, 010=250, 011=400, 100=667, 101=1000, 110=2000, 111=4000. In tach mode without two pulses, the edge that samples the window's last tick ends spin-up and sets `irq_fail`.
- R5: In tach mode with `tmo_sel`=000, spin-up continues without limit until two pulses arrive, and `irq_fail` is never set.
- R6: With `fixed_mode`=1, tach pulses are ignored. Spin-up lasts exactly the selected number of ticks and `irq_fail` is not set. With `tmo_sel`=000, spin-up lasts a single cycle.
- R7: `irq_fail` stays set until a cycle with `irq_clr`=1 clears it. A new failure in the same cycle wins over the clear.
- R8: Dropping `fan_en` at any time returns the block to idle on the next edge, with `duty_out`=0. A tach pulse counted before the drop does not carry into the next spin-up.
- R9: After spin-up, `duty_out` follows `run_duty` in the same cycle.
- R10: If the second tach pulse and the window's last tick fall on the same edge, spin-up ends without raising `irq_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| fan_en | input | 1 | Fan enable; a rise starts spin-up |
| tach_pulse | input | 1 | Synchronized one-cycle tach edge |
| tmo_sel | input | 3 | Window / fixed-time select |
| fixed_mode | input | 1 | 1 = fixed-time spin-up, no tach detection |
| run_duty | input | DUTY_W | Requested running duty |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| duty_out | output | DUTY_W | Duty sent to the PWM generator |
| spinning_up | output | 1 | High while the full-duty burst is active |
| irq_fail | output | 1 | Sticky startup-failure interrupt |

## Verification
All outputs come straight from the state register, so each result appears right after the edge that samples its cause. Spin-up shows one edge after the enable, and running duty shows after the edge that samples the second tach pulse. After the enable edge, a window of N ticks with `ms_tick` held high ends after exactly N more edges. The bench drives inputs shortly after a rising edge and compares outputs in that same cycle, so each check sits between the causing edge and the next one. Window ends are counted edge by edge for every select value in both modes.

// File: rtl/fan_spinup_ctrl.sv
module fan_spinup_ctrl #(
  parameter int DUTY_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              fan_en,
  input  logic              tach_pulse,
  input  logic [2:0]        tmo_sel,
  input  logic              fixed_mode,
  input  logic [DUTY_W-1:0] run_duty,
  input  logic              irq_clr,
  output logic [DUTY_W-1:0] duty_out,
  output logic              spinning_up,
  output logic              irq_fail
);
  typedef enum logic [1:0] {S_IDLE, S_SPIN, S_RUN} st_t;
  localparam logic [DUTY_W-1:0] FULL = '1;

  st_t              st;
  logic [CNT_W-1:0] ms_cnt, limit;
  logic             seen_one, hit, second, tmo_evt;

  always_comb begin
    case (tmo_sel)
      3'd1:    limit = CNT_W'(100);
      3'd2:    limit = CNT_W'(250);
      3'd3:    limit = CNT_W'(400);
      3'd4:    limit = CNT_W'(667);
      3'd5:    limit = CNT_W'(1000);
      3'd6:    limit = CNT_W'(2000);
      3'd7:    limit = CNT_W'(4000);
      default: limit = '0;
    endcase
  end

  assign hit     = ms_tick && (limit != '0) && (ms_cnt == limit - 1'b1);
  assign second  = tach_pulse && seen_one;
  assign tmo_evt = fan_en && st == S_SPIN && !fixed_mode && !second && hit;

  always_ff @(posedge clk) begin
    if (!rst_n || !fan_en) begin
      st       <= S_IDLE;
      ms_cnt   <= '0;
      seen_one <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          st       <= S_SPIN;
          ms_cnt   <= '0;
          seen_one <= 1'b0;
        end
        S_SPIN: begin
          if (fixed_mode) begin
            if (limit == '0 || hit) st <= S_RUN;
            else if (ms_tick)       ms_cnt <= ms_cnt + 1'b1;
          end else if (second || hit) begin
            st <= S_RUN;
          end else begin
            if (tach_pulse) seen_one <= 1'b1;
            if (ms_tick)    ms_cnt <= ms_cnt + 1'b1;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_fail <= 1'b0;
    else if (tmo_evt) irq_fail <= 1'b1;
    else if (irq_clr) irq_fail <= 1'b0;
  end

  assign spinning_up = (st == S_SPIN);
  assign duty_out    = (st == S_SPIN) ? FULL : (st == S_RUN) ? run_duty : '0;

  // R2
  start_spin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_en && st == S_IDLE) |=> (spinning_up && duty_out == FULL));
  // R8
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fan_en |=> (!spinning_up && duty_out == '0));
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fail && !irq_clr) |=> irq_fail);
  // R6
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fail) |-> $past(!fixed_mode && tmo_sel != 3'd0 && spinning_up));
  // R4
  irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fail) |-> !spinning_up);
  // R3
  run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spinning_up && fan_en && !fixed_mode && second) |=> (!spinning_up && !irq_fail || $past(irq_fail)));
endmodule

// File: tb/sim_fan_spinup_ctrl.sv
module sim_fan_spinup_ctrl;
  logic clk = 0, rst_n = 0, ms_tick = 0, fan_en = 0, tach_pulse = 0;
  logic fixed_mode = 0, irq_clr = 0;
  logic [2:0] tmo_sel = 3'd2;
  logic [7:0] run_duty = 8'h55, duty_out;
  logic spinning_up, irq_fail;
  int nvec = 0, nerr = 0;
  bit done = 0;

  fan_spinup_ctrl u0 (.clk, .rst_n, .ms_tick, .fan_en, .tach_pulse, .tmo_sel,
    .fixed_mode, .run_duty, .irq_clr, .duty_out, .spinning_up, .irq_fail);

  always #10 clk = ~clk;

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int win(int s);
    int t[8] = '{0, 100, 250, 400, 667, 1000, 2000, 4000};
    return t[s];
  endfunction

  task automatic restart();
    fan_en = 0; tach_pulse = 0; irq_clr = 1; step(); step();
    irq_clr = 0; fan_en = 1; step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 duty", duty_out, 0); chk("R1 spin", spinning_up, 0); chk("R1 irq", irq_fail, 0);
    rst_n = 1; step();
    chk("R1 idle", duty_out, 0);
    ms_tick = 1;

    for (int fm = 0; fm < 2; fm++)
      for (int s = 1; s < 8; s++) begin
        fixed_mode = fm[0]; tmo_sel = 3'(s);
        restart();
        chk("R2 spin", spinning_up, 1); chk("R2 duty", duty_out, 8'hff);
        for (int i = 1; i < win(s); i++) begin
          if (fm == 1) tach_pulse = (i % 3 == 0);
          step();
        end
        tach_pulse = 0;
        chk(fm ? "R6 still spinning" : "R4 still spinning", spinning_up, 1);
        step();
        chk(fm ? "R6 ended" : "R4 ended", spinning_up, 0);
        chk(fm ? "R6 no irq" : "R4 irq", irq_fail, fm ? 0 : 1);
        chk("R9 duty", duty_out, run_duty);
      end

    fixed_mode = 1; tmo_sel = 0; restart();
    chk("R6 one cycle spin", spinning_up, 1);
    step(); chk("R6 zero window", spinning_up, 0); chk("R6 no irq", irq_fail, 0);

    fixed_mode = 0; tmo_sel = 0; restart();
    repeat (5000) step();
    chk("R5 waiting", spinning_up, 1); chk("R5 no irq", irq_fail, 0);
    tach_pulse = 1; step(); tach_pulse = 0; repeat (7) step();
    chk("R5 one pulse", spinning_up, 1);
    tach_pulse = 1; step(); tach_pulse = 0;
    chk("R3 run", spinning_up, 0); chk("R3 duty", duty_out, run_duty); chk("R5 irq", irq_fail, 0);

    for (int g = 1; g < 40; g += 7) begin
      tmo_sel = 3'd1; restart();
      tach_pulse = 1; step(); tach_pulse = 0;
      repeat (g) step();
      chk("R3 after one", spinning_up, 1);
      tach_pulse = 1; step(); tach_pulse = 0;
      chk("R3 after two", spinning_up, 0); chk("R3 no irq", irq_fail, 0);
    end

    for (int d = 0; d < 256; d += 37) begin
      run_duty = 8'(d); #1; chk("R9 follow", duty_out, d);
    end

    tmo_sel = 3'd1; restart();
    tach_pulse = 1; step(); tach_pulse = 0;
    repeat (50) step();
    fan_en = 0; step();
    chk("R8 idle", spinning_up, 0); chk("R8 duty", duty_out, 0);
    fan_en = 1; step();
    tach_pulse = 1; step(); tach_pulse = 0;
    chk("R8 count cleared", spinning_up, 1);

    tmo_sel = 3'd1; restart();
    tach_pulse = 1; step(); tach_pulse = 0;
    repeat (win(1) - 2) step();
    tach_pulse = 1; step(); tach_pulse = 0;
    chk("R10 ended", spinning_up, 0); chk("R10 no irq", irq_fail, 0);

    tmo_sel = 3'd1; restart();
    repeat (win(1)) step();
    chk("R7 set", irq_fail, 1);
    repeat (20) step(); chk("R7 sticky", irq_fail, 1);
    fan_en = 0; step(); chk("R7 held in idle", irq_fail, 1);
    irq_clr = 1; step(); irq_clr = 0; chk("R7 cleared", irq_fail, 0);
    fan_en = 1; step();
    repeat (win(1) - 1) step();
    irq_clr = 1; step(); irq_clr = 0;
    chk("R7 set beats clear", irq_fail, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule